// File: doc/BRIEF.md
# Misaligned Load/Store Splitter

This block sits between a load/store unit and a 32-bit, byte-addressable memory. It takes one request at a time: an access size (byte, halfword or word), a read/write flag, a byte address and store data. It turns that request into one or two aligned word accesses. A request whose bytes all sit in one memory word uses a single access. A request whose bytes run past the end of a word uses two accesses in a row: the first goes to the word that holds the start address, and the second goes to the next word up.

For stores, the block rotates the store data so that each byte lands on its memory lane, and it raises the write enable only for the lanes that the current access covers. For loads, it collects the lanes returned by each access into the matching result byte. It then hands back a right-justified, zero-extended value. The block drives a chip enable from the top address bit (bit 28 of a 512 MB space) and a flag that marks the second access.

Requests arrive on a valid/ready stream and results leave on another one. A request is taken only while the block is idle. A result stays on the outputs until the consumer takes it. The memory side is a plain request/acknowledge pair.

Top module: `span_access_ctrl`

## Requirements
- R1: The size field encodes byte as 00, halfword as 01 and word as 10. These cover 1, 2 and 4 bytes starting at the request address.
- R2: The first access goes to word address `in_addr[28:2]`, with `mem_second` low.
- R3: A second access is made exactly when `in_addr[1:0]` plus the size in bytes is more than 4. It goes to the first word address plus one, wrapping within 27 bits, with `mem_second` high.
- R4: `mem_be[i]` is high exactly when byte lane i holds a byte of the request for the current access. Lane i carries bits [8i+7:8i] of `mem_wdata`. `mem_write` follows the request's write flag.
- R5: On a store, lane i of `mem_wdata` carries byte ((i - addr[1:0]) mod 4) of the store data.
- R6: On a load, the byte at request address + k is returned in `out_rdata[8k+7:8k]`. Bytes at or above the size are zero. A store returns `out_rdata` = 0.
- R7: `mem_chip_en` equals bit 28 of the current access's byte address, which is the top bit of `mem_addr`.
- R8: A request with size 11 makes no memory access and answers with `out_err` = 1 and `out_rdata` = 0. It does not change memory. Legal requests answer with `out_err` = 0.
- R9: `in_ready` is high only while no request is in progress. `out_valid`, `out_rdata` and `out_err` stay steady until `out_ready` is seen. Each accepted request gives exactly one response.
- R10: `mem_req`, `mem_addr`, `mem_be` and `mem_second` stay steady until `mem_ack`. The response follows the final acknowledged access on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high with in_valid |
| in_size | input | 2 | Access size code |
| in_write | input | 1 | 1 = store, 0 = load |
| in_addr | input | 29 | Byte address |
| in_wdata | input | 32 | Right-justified store data |
| out_valid | output | 1 | Response valid |
| out_ready | input | 1 | Response taken when high with out_valid |
| out_rdata | output | 32 | Right-justified, zero-extended load data |
| out_err | output | 1 | Illegal size flag |
| mem_req | output | 1 | Memory access request |
| mem_ack | input | 1 | Memory completed the current access |
| mem_write | output | 1 | Access is a write |
| mem_addr | output | 27 | Word address |
| mem_be | output | 4 | Per-lane byte enables |
| mem_second | output | 1 | High on the second access of a split request |
| mem_chip_en | output | 1 | Active-high chip enable from address bit 28 |
| mem_wdata | output | 32 | Lane-aligned store data |
| mem_rdata | input | 32 | Word read from memory, valid with mem_ack |

## Verification
The assertions assume that memory raises `mem_ack` only while `mem_req` is high. They also assume `mem_rdata` is valid in the acknowledge cycle and that the consumer may hold `out_ready` low for any number of cycles. The bench memory acknowledges each request one cycle after it rises, and it drops the acknowledge right after each completed access. It never acknowledges a request twice. The stimulus sweeps every size code, offset and direction at three base words, including one whose second access carries address bit 28 from 0 to 1. It also holds some responses back for several cycles.

// File: rtl/span_pkg.sv
package span_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_BAD  = 2'b11
  } xfer_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MEM  = 2'd1,
    ST_RESP = 2'd2
  } seq_state_e;
endpackage

// File: rtl/span_lane_planner.sv
// Works out which byte lanes a request covers, across two neighbouring words.
module span_lane_planner #(
  parameter int LANES = 4,
  localparam int OFF_W = $clog2(LANES),
  localparam int CNT_W = OFF_W + 1
) (
  input  logic [OFF_W-1:0] off,
  input  logic [CNT_W-1:0] nbytes,
  input  logic             second,
  output logic [LANES-1:0] be,
  output logic             split
);
  logic [2*LANES-1:0] span;

  for (genvar g = 0; g < 2*LANES; g++) begin : g_span
    assign span[g] = (g >= int'(off)) && (g < int'(off) + int'(nbytes));
  end

  assign split = |span[2*LANES-1:LANES];
  assign be    = second ? span[2*LANES-1:LANES] : span[LANES-1:0];
endmodule

// File: rtl/span_byte_rotator.sv
// Rotates whole bytes by a lane count; the parameter picks the direction.
module span_byte_rotator #(
  parameter int LANES = 4,
  parameter bit ROT_RIGHT = 1'b0,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic [8*LANES-1:0] din,
  input  logic [OFF_W-1:0]   amt,
  output logic [8*LANES-1:0] dout
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [OFF_W-1:0] src;
    if (ROT_RIGHT) begin : g_right
      assign src = OFF_W'(g) + amt;
    end else begin : g_left
      assign src = OFF_W'(g) - amt;
    end
    assign dout[8*g +: 8] = din[8*src +: 8];
  end
endmodule

// File: rtl/span_load_gather.sv
// Collects returned lanes into result byte order, then zero-extends.
module span_load_gather #(
  parameter int LANES = 4,
  localparam int OFF_W = $clog2(LANES),
  localparam int CNT_W = OFF_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               capture,
  input  logic [OFF_W-1:0]   off,
  input  logic [LANES-1:0]   be,
  input  logic [CNT_W-1:0]   nbytes,
  input  logic [8*LANES-1:0] rdata,
  output logic [8*LANES-1:0] result
);
  logic [8*LANES-1:0] rot_data;
  logic [8*LANES-1:0] gather_q;
  logic [LANES-1:0]   rot_be;

  span_byte_rotator #(.LANES(LANES), .ROT_RIGHT(1'b1)) u_rot (
    .din (rdata),
    .amt (off),
    .dout(rot_data)
  );

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign rot_be[j] = be[OFF_W'(OFF_W'(j) + off)];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    gather_q[8*j +: 8] <= '0;
      else if (clear)                gather_q[8*j +: 8] <= '0;
      else if (capture && rot_be[j]) gather_q[8*j +: 8] <= rot_data[8*j +: 8];
    end

    assign result[8*j +: 8] = (CNT_W'(j) < nbytes) ? gather_q[8*j +: 8] : 8'h00;
  end
endmodule

// File: rtl/span_access_ctrl.sv
module span_access_ctrl
  import span_pkg::*;
#(
  parameter int ADDR_W = 29,
  parameter int DATA_W = 32,
  localparam int LANES   = DATA_W / 8,
  localparam int OFF_W   = $clog2(LANES),
  localparam int CNT_W   = OFF_W + 1,
  localparam int WADDR_W = ADDR_W - OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [1:0]         in_size,
  input  logic               in_write,
  input  logic [ADDR_W-1:0]  in_addr,
  input  logic [DATA_W-1:0]  in_wdata,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [DATA_W-1:0]  out_rdata,
  output logic               out_err,
  output logic               mem_req,
  input  logic               mem_ack,
  output logic               mem_write,
  output logic [WADDR_W-1:0] mem_addr,
  output logic [LANES-1:0]   mem_be,
  output logic               mem_second,
  output logic               mem_chip_en,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic [DATA_W-1:0]  mem_rdata
);
  seq_state_e        state_q;
  xfer_size_e        size_q;
  logic              write_q, second_q, err_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [CNT_W-1:0]  nbytes;
  logic              split;
  logic              accept;
  logic [OFF_W-1:0]  off;
  logic [WADDR_W-1:0] word0;
  logic [DATA_W-1:0] gathered;

  assign accept = in_valid && in_ready;
  assign off    = addr_q[OFF_W-1:0];
  assign word0  = addr_q[ADDR_W-1:OFF_W];

  always_comb begin
    case (size_q)
      SZ_BYTE: nbytes = CNT_W'(1);
      SZ_HALF: nbytes = CNT_W'(2);
      SZ_WORD: nbytes = CNT_W'(4);
      default: nbytes = '0;
    endcase
  end

  span_lane_planner #(.LANES(LANES)) u_plan (
    .off   (off),
    .nbytes(nbytes),
    .second(second_q),
    .be    (mem_be),
    .split (split)
  );

  span_byte_rotator #(.LANES(LANES), .ROT_RIGHT(1'b0)) u_wrot (
    .din (wdata_q),
    .amt (off),
    .dout(mem_wdata)
  );

  span_load_gather #(.LANES(LANES)) u_gather (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (accept),
    .capture(state_q == ST_MEM && mem_ack && !write_q),
    .off    (off),
    .be     (mem_be),
    .nbytes (nbytes),
    .rdata  (mem_rdata),
    .result (gathered)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      size_q   <= SZ_BYTE;
      write_q  <= 1'b0;
      second_q <= 1'b0;
      err_q    <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (in_valid) begin
          size_q   <= xfer_size_e'(in_size);
          write_q  <= in_write;
          addr_q   <= in_addr;
          wdata_q  <= in_wdata;
          second_q <= 1'b0;
          err_q    <= (in_size == SZ_BAD);
          state_q  <= (in_size == SZ_BAD) ? ST_RESP : ST_MEM;
        end
        ST_MEM: if (mem_ack) begin
          if (!second_q && split) second_q <= 1'b1;
          else                    state_q  <= ST_RESP;
        end
        ST_RESP: if (out_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign in_ready    = (state_q == ST_IDLE);
  assign mem_req     = (state_q == ST_MEM);
  assign mem_write   = write_q;
  assign mem_second  = second_q;
  assign mem_addr    = second_q ? word0 + WADDR_W'(1) : word0;
  assign mem_chip_en = mem_addr[WADDR_W-1];
  assign out_valid   = (state_q == ST_RESP);
  assign out_err     = err_q;
  assign out_rdata   = err_q ? '0 : gathered;

  // R8: an illegal size goes straight to an error response
  assert_bad_size_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_size == 2'b11 |=> out_valid && out_err && !mem_req);

  // R10: the access is held until memory acknowledges it
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_be) && $stable(mem_second));

  // R9: the response is held until it is taken
  assert_resp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_rdata) && $stable(out_err));

  // R9: one response per request
  assert_one_resp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> !out_valid);

  // R3: a second access always starts at lane 0 and ends the request
  assert_second_lane0_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_second |-> mem_be[0]);

  assert_second_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && mem_second |=> out_valid);

  // R4: every access enables at least one lane
  assert_be_any_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_be != '0);
endmodule

// File: tb/span_access_ctrl_tb_top.sv
module span_access_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_size = 2'b00;
  logic        in_write = 1'b0;
  logic [28:0] in_addr = '0;
  logic [31:0] in_wdata = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_rdata;
  logic        out_err;
  logic        mem_req, mem_ack, mem_write, mem_second, mem_chip_en;
  logic [26:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata, mem_rdata;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [7:0] mem [64];
  logic [7:0] ref_mem [64];
  logic       ack_q;

  always #4 clk = ~clk;

  span_access_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_size(in_size),
    .in_write(in_write), .in_addr(in_addr), .in_wdata(in_wdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_rdata(out_rdata),
    .out_err(out_err), .mem_req(mem_req), .mem_ack(mem_ack),
    .mem_write(mem_write), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_second(mem_second), .mem_chip_en(mem_chip_en),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // memory model: acknowledge one cycle after a request appears
  assign mem_ack = ack_q;
  always_comb begin
    for (int l = 0; l < 4; l++) mem_rdata[8*l +: 8] = mem[{mem_addr[3:0], 2'(l)}];
  end
  always @(posedge clk) begin
    if (!rst_n) ack_q <= 1'b0;
    else begin
      ack_q <= mem_req && !ack_q;
      if (mem_req && ack_q && mem_write)
        for (int l = 0; l < 4; l++)
          if (mem_be[l]) mem[{mem_addr[3:0], 2'(l)}] <= mem_wdata[8*l +: 8];
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [28:0] a, input logic [1:0] sz, input logic wr,
                      input logic [31:0] wd, input int hold);
    int n, off, nacc, guard;
    logic [7:0] span;
    logic [31:0] exp_r, first_r;
    logic [26:0] w;
    bit legal;
    legal = (sz != 2'b11);
    n = legal ? (1 << sz) : 0;
    off = int'(a[1:0]);
    span = '0;
    for (int i = 0; i < 8; i++) if (i >= off && i < off + n) span[i] = 1'b1;
    exp_r = '0;
    if (legal && !wr)
      for (int k = 0; k < n; k++) exp_r[8*k +: 8] = ref_mem[6'(a + 29'(k))];
    @(negedge clk);
    in_valid = 1'b1; in_size = sz; in_write = wr; in_addr = a; in_wdata = wd;
    @(negedge clk);
    in_valid = 1'b0;
    nacc = 0; guard = 0;
    while (!out_valid && guard < 50) begin
      if (mem_req && mem_ack) begin
        w = a[28:2] + 27'(nacc);
        check("R2/R3 word address", 32'(mem_addr), 32'(w));
        check("R3 second flag", 32'(mem_second), 32'(nacc));
        check("R4 byte enables", 32'(mem_be), 32'(nacc == 0 ? span[3:0] : span[7:4]));
        check("R4 write flag", 32'(mem_write), 32'(wr));
        check("R7 chip enable", 32'(mem_chip_en), 32'(w[26]));
        if (wr)
          for (int l = 0; l < 4; l++)
            if (mem_be[l]) check("R5 lane data", 32'(mem_wdata[8*l +: 8]), 32'(wd[8*(((l - off) % 4 + 4) % 4) +: 8]));
        nacc++;
      end
      @(negedge clk);
      guard++;
    end
    check("R3 access count", 32'(nacc), legal ? ((off + n > 4) ? 2 : 1) : 0);
    check("R6 load data", out_rdata, exp_r);
    check("R8 error flag", 32'(out_err), 32'(!legal));
    first_r = out_rdata;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      check("R9 held valid", 32'(out_valid), 32'd1);
      check("R9 held data", out_rdata, first_r);
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check("R9 one response", 32'(out_valid), 32'd0);
    check("R9 ready when idle", 32'(in_ready), 32'd1);
    if (legal && wr)
      for (int k = 0; k < n; k++) ref_mem[6'(a + 29'(k))] = wd[8*k +: 8];
  endtask

  initial begin
    logic [28:0] bases [3];
    int cnt;
    bases[0] = 29'h1000_0010;
    bases[1] = 29'h0FFF_FFFC;
    bases[2] = 29'h1000_0020;
    for (int i = 0; i < 64; i++) begin
      mem[i] = 8'(i * 37 + 5);
      ref_mem[i] = 8'(i * 37 + 5);
    end
    repeat (3) @(negedge clk);
    check("R9 reset in_ready", 32'(in_ready), 32'd1);
    check("R9 reset out_valid", 32'(out_valid), 32'd0);
    check("R10 reset mem_req", 32'(mem_req), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    cnt = 0;
    // R1: all size codes, all offsets, store then load at each spot
    for (int b = 0; b < 3; b++)
      for (int s = 0; s < 4; s++)
        for (int o = 0; o < 4; o++)
          for (int d = 1; d >= 0; d--) begin
            xfer(bases[b] + 29'(o), 2'(s), d[0], 32'h1122_3344 + 32'(cnt) * 32'h0103_0507,
                 (cnt % 5 == 0) ? 3 : 0);
            cnt++;
          end
    // R8: memory untouched by illegal stores, read back as words
    for (int b = 0; b < 3; b++) xfer(bases[b], 2'b10, 1'b0, '0, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule